// File: doc/BRIEF.md
# High-Resolution PWM Edge Extender

This block sits between a timer/counter and the output pins it drives. It lets the timer place a waveform edge inside a timer tick rather than only on a tick boundary. The block runs on a fast clock at eight times the timer's tick rate. A tick strobe marks the first fast cycle of every tick. The timer supplies, for each channel, its count in ticks and a compare value pre-scaled by the resolution factor. The upper compare bits pick the tick that holds the falling edge, and the low compare bits pick the sub-slot inside that tick.

A small control register selects the mode. One enable bit per channel turns on fine placement, and one bit chooses between quarter-tick and eighth-tick resolution. If any enable bit is set, the whole shared pin group switches to the fine path. A channel whose own bit is clear is then held low. Compare values that would give a high pulse shorter than one tick are suppressed. Count, compare and mode values are sampled only on the tick strobe, so nothing changes within a tick.

Each channel is steered by a five-state machine:
- `WV_LOW` drives the pin low.
- `WV_HIGH` drives the pin high.
- `WV_EDGE` drives the pin high until the chosen sub-slot is reached, then moves to `WV_LOW`.
- `WV_MUTED` holds a suppressed short pulse low.
- `WV_PARKED` holds a disabled channel low while the pin group is in fine mode.

On every tick strobe each machine is reloaded from the new count, compare and mode. The only transition inside a tick is `WV_EDGE` to `WV_LOW`, taken when the next fast cycle's sub-slot is at or beyond the compare sub-slot. All other states hold until the next strobe.

Top module: `hrpwm_edge_ext`

## Requirements
- R1: The control register holds the channel enables in bits 1:0 (bit 0 for channel 0, bit 1 for channel 1) and the eighth-tick resolution select in bit 2. Bits 7:3 read as zero and ignore writes. The whole register resets to zero, and a write is visible on `reg_rdata` after the clock edge that samples it.
- R2: Count, compare, enable and resolution values take effect only at the clock edge that samples `tick` high. Changes at any other time do not alter the pin waveform of the tick in progress.
- R3: Enable field encoding is 00 for no channel, 01 for channel 0, 10 for channel 1 and 11 for both. With a nonzero field the pin group is in fine mode, and a channel whose enable bit is 0 drives its pin low.
- R4: With the enable field 00, a pin is high for a whole tick when count < cmp[3:0] and low otherwise. Its edges fall only on tick boundaries.
- R5: In quarter-tick mode (bit 2 = 0, channel enabled), sub-slot q = s/2 for fast cycle s (0..7) of the tick. The pin is high while 4*count + q < cmp, where cmp[1:0] selects the quarter and the upper bits select the tick.
- R6: In eighth-tick mode (bit 2 = 1, channel enabled), the pin is high while 8*count + s < cmp. Here cmp[2:0] selects the fast cycle and the upper bits select the tick.
- R7: For an enabled channel, a compare value below 4 in quarter-tick mode, or below 8 in eighth-tick mode, keeps the pin low for the entire tick.
- R8: The pin level for fast cycle k (k = 0..7) of a tick appears after clock edge k+1, counting the edge that samples `tick` as edge 0, and holds until the next edge.
- R9: During and directly after reset, every pin is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, eight times the tick rate |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | REG_W | Control register write data |
| reg_rdata | output | REG_W | Control register contents |
| tick | input | 1 | High on the first fast cycle of each tick |
| count_i | input | NUM_TIMERS*CNT_W | Per-channel tick count, channel 0 in the low bits |
| cmp_i | input | NUM_TIMERS*(CNT_W+3) | Per-channel scaled compare value, channel 0 in the low bits |
| pin_o | output | NUM_TIMERS | Waveform pins |

## Verification
The hardest situation to reach from the ports is an `WV_EDGE` tick whose falling sub-slot lands on every possible position, in both resolutions. Each such tick must also be checked against the suppression threshold and against a partner channel that may be parked. The stimulus gets there by sweeping every compare value against every count for each mode, with the second channel on the mirrored compare. Between strobes the bench scrambles the count and compare inputs, so any leak of unsampled values shows up. Separate ticks rewrite the control register mid-tick and expect the old mode until the next strobe.

// File: rtl/hrpwm_pkg.sv
package hrpwm_pkg;

    // Fast-clock cycles per peripheral tick
    localparam int SUB_N = 8;
    localparam int SUB_W = $clog2(SUB_N);
    // Shift that separates tick and quarter bits in quarter-tick mode
    localparam int NORM_SH = SUB_W - 1;

    typedef enum logic [2:0] {
        WV_LOW,
        WV_HIGH,
        WV_EDGE,
        WV_MUTED,
        WV_PARKED
    } wv_state_t;

    // Sub-slot index for a fast-cycle position, by resolution
    function automatic logic [SUB_W-1:0] slot_of(
        input logic [SUB_W-1:0] sub,
        input logic             fine8
    );
        return fine8 ? sub : (sub >> 1);
    endfunction

endpackage

// File: rtl/hrpwm_ctrl_reg.sv
module hrpwm_ctrl_reg #(
    parameter  int NUM_TIMERS = 2,
    parameter  int REG_W      = 8,
    localparam int FINE_BIT   = NUM_TIMERS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [REG_W-1:0]      wdata,
    input  logic                  tick,
    output logic [REG_W-1:0]      rdata,
    output logic [NUM_TIMERS-1:0] en_cfg,
    output logic                  fine_cfg,
    output logic [NUM_TIMERS-1:0] en_act,
    output logic                  fine_act
);

    logic [NUM_TIMERS-1:0] en_q;
    logic                  fine_q;
    logic [NUM_TIMERS-1:0] en_sh;
    logic                  fine_sh;
    logic                  unused_reserved;

    // Programmed value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            fine_q <= 1'b0;
        end else if (we) begin
            en_q   <= wdata[NUM_TIMERS-1:0];
            fine_q <= wdata[FINE_BIT];
        end
    end

    // Applied value, refreshed on each tick strobe only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_sh   <= '0;
            fine_sh <= 1'b0;
        end else if (tick) begin
            en_sh   <= en_q;
            fine_sh <= fine_q;
        end
    end

    always_comb begin
        rdata                   = '0;
        rdata[NUM_TIMERS-1:0]   = en_q;
        rdata[FINE_BIT]         = fine_q;
    end

    assign unused_reserved = ^wdata[REG_W-1:FINE_BIT+1];
    assign en_cfg   = en_q;
    assign fine_cfg = fine_q;
    assign en_act   = en_sh;
    assign fine_act = fine_sh;

endmodule

// File: rtl/hrpwm_subslot_seq.sv
module hrpwm_subslot_seq
    import hrpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             fine_act,
    output logic [SUB_W-1:0] sub_o,
    output logic [SUB_W-1:0] slot_next_o
);

    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_N - 1);

    logic [SUB_W-1:0] sub_q;
    logic [SUB_W-1:0] sub_nx;

    // Fast-cycle position in the tick; parks on the last slot when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q <= SUB_LAST;
        end else if (tick) begin
            sub_q <= '0;
        end else if (sub_q != SUB_LAST) begin
            sub_q <= sub_q + 1'b1;
        end
    end

    assign sub_nx      = (sub_q == SUB_LAST) ? sub_q : sub_q + 1'b1;
    assign slot_next_o = slot_of(sub_nx, fine_act);
    assign sub_o       = sub_q;

endmodule

// File: rtl/hrpwm_edge_fsm.sv
module hrpwm_edge_fsm
    import hrpwm_pkg::*;
#(
    parameter  int CNT_W = 4,
    localparam int CMP_W = CNT_W + SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             port_fine,
    input  logic             chan_en,
    input  logic             fine8,
    input  logic [CNT_W-1:0] count,
    input  logic [CMP_W-1:0] cmp,
    input  logic [SUB_W-1:0] slot_next,
    output logic             pin,
    output logic             muted
);

    localparam logic [CMP_W-1:0] MIN_NORM = CMP_W'(1 << NORM_SH);
    localparam logic [CMP_W-1:0] MIN_FINE = CMP_W'(SUB_N);

    wv_state_t        st_q, st_d, st_load;
    logic [SUB_W-1:0] csub_q, csub_d, csub_in;
    logic [CMP_W-1:0] cnt_ext;
    logic [CMP_W-1:0] tick_norm;
    logic [CMP_W-1:0] tick_fine;
    logic [CMP_W-1:0] tick_sel;
    logic             too_short;
    logic             plain_hi;
    logic             pin_d;
    logic             pin_q;

    // Split the scaled compare into tick and sub-slot parts
    always_comb begin
        cnt_ext   = CMP_W'(count);
        tick_norm = cmp >> NORM_SH;
        tick_fine = cmp >> SUB_W;
        tick_sel  = fine8 ? tick_fine : tick_norm;
        csub_in   = fine8 ? cmp[SUB_W-1:0] : SUB_W'(cmp[NORM_SH-1:0]);
        too_short = fine8 ? (cmp < MIN_FINE) : (cmp < MIN_NORM);
        plain_hi  = (count < cmp[CNT_W-1:0]);
    end

    // State chosen when a new tick starts
    always_comb begin
        if (!port_fine) begin
            st_load = plain_hi ? WV_HIGH : WV_LOW;
        end else if (!chan_en) begin
            st_load = WV_PARKED;
        end else if (too_short) begin
            st_load = WV_MUTED;
        end else if (cnt_ext < tick_sel) begin
            st_load = WV_HIGH;
        end else if ((cnt_ext == tick_sel) && (csub_in != '0)) begin
            st_load = WV_EDGE;
        end else begin
            st_load = WV_LOW;
        end
    end

    // Next-state logic
    always_comb begin
        st_d   = st_q;
        csub_d = csub_q;
        if (tick) begin
            st_d   = st_load;
            csub_d = csub_in;
        end else begin
            unique case (st_q)
                WV_EDGE: begin
                    if (slot_next >= csub_q) begin
                        st_d = WV_LOW;
                    end
                end
                WV_LOW, WV_HIGH, WV_MUTED, WV_PARKED: begin
                    st_d = st_q;
                end
                default: begin
                    st_d = WV_LOW;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WV_LOW;
            csub_q <= '0;
        end else begin
            st_q   <= st_d;
            csub_q <= csub_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (st_q)
            WV_HIGH, WV_EDGE:               pin_d = 1'b1;
            WV_LOW, WV_MUTED, WV_PARKED:    pin_d = 1'b0;
            default:                        pin_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign pin   = pin_q;
    assign muted = (st_q == WV_MUTED);

endmodule

// File: rtl/hrpwm_edge_ext.sv
module hrpwm_edge_ext
    import hrpwm_pkg::*;
#(
    parameter  int NUM_TIMERS = 2,
    parameter  int CNT_W      = 4,
    parameter  int REG_W      = 8,
    localparam int CMP_W      = CNT_W + SUB_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [REG_W-1:0]            reg_wdata,
    output logic [REG_W-1:0]            reg_rdata,
    input  logic                        tick,
    input  logic [NUM_TIMERS*CNT_W-1:0] count_i,
    input  logic [NUM_TIMERS*CMP_W-1:0] cmp_i,
    output logic [NUM_TIMERS-1:0]       pin_o
);

    logic [NUM_TIMERS-1:0] en_cfg;
    logic                  fine_cfg;
    logic [NUM_TIMERS-1:0] en_act;
    logic                  fine_act;
    logic                  port_fine;
    logic [SUB_W-1:0]      sub_q;
    logic [SUB_W-1:0]      slot_next;
    logic [NUM_TIMERS-1:0] muted;

    hrpwm_ctrl_reg #(
        .NUM_TIMERS (NUM_TIMERS),
        .REG_W      (REG_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .wdata    (reg_wdata),
        .tick     (tick),
        .rdata    (reg_rdata),
        .en_cfg   (en_cfg),
        .fine_cfg (fine_cfg),
        .en_act   (en_act),
        .fine_act (fine_act)
    );

    hrpwm_subslot_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .fine_act    (fine_act),
        .sub_o       (sub_q),
        .slot_next_o (slot_next)
    );

    // Any enable bit moves the shared pin group onto the fine path
    assign port_fine = |en_cfg;

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_chan
        hrpwm_edge_fsm #(
            .CNT_W (CNT_W)
        ) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .port_fine (port_fine),
            .chan_en   (en_cfg[t]),
            .fine8     (fine_cfg),
            .count     (count_i[t*CNT_W +: CNT_W]),
            .cmp       (cmp_i[t*CMP_W +: CMP_W]),
            .slot_next (slot_next),
            .pin       (pin_o[t]),
            .muted     (muted[t])
        );
    end

endmodule

// File: rtl/hrpwm_edge_ext_chk.sv
module hrpwm_edge_ext_chk #(
    parameter int NUM_TIMERS = 2,
    parameter int REG_W      = 8,
    parameter int SUB_W      = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [REG_W-1:0]      reg_rdata,
    input logic                  tick,
    input logic [NUM_TIMERS-1:0] pin,
    input logic [NUM_TIMERS-1:0] en_act,
    input logic [SUB_W-1:0]      sub,
    input logic [NUM_TIMERS-1:0] muted
);

    // R1: reserved bits never read back as one
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:NUM_TIMERS+1] == '0);

    // R2: applied enables change only on a tick strobe
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(en_act));

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_prop
        // R3: disabled channel in a fine-mode group stays low
        a_r3_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
            ((|en_act) && !en_act[t]) |=> !pin[t]);

        // R4: plain mode only moves the pin at a tick boundary
        a_r4_plain_aligned: assert property (@(posedge clk) disable iff (!rst_n)
            (!(|en_act) && (sub != '0)) |=> $stable(pin[t]));

        // R7: a suppressed short pulse never reaches the pin
        a_r7_muted_low: assert property (@(posedge clk) disable iff (!rst_n)
            muted[t] |=> !pin[t]);
    end

endmodule

bind hrpwm_edge_ext hrpwm_edge_ext_chk #(
    .NUM_TIMERS (NUM_TIMERS),
    .REG_W      (REG_W),
    .SUB_W      (SUB_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .tick      (tick),
    .pin       (pin_o),
    .en_act    (en_act),
    .sub       (sub_q),
    .muted     (muted)
);

// File: tb/test_hrpwm_edge_ext.sv
`timescale 1ns/1ps
module test_hrpwm_edge_ext;

    localparam int NT = 2;
    localparam int CW = 4;
    localparam int MW = CW + 3;
    localparam int RW = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [RW-1:0]    reg_wdata = '0;
    logic [RW-1:0]    reg_rdata;
    logic             tick = 1'b0;
    logic [NT*CW-1:0] count_i = '0;
    logic [NT*MW-1:0] cmp_i = '0;
    logic [NT-1:0]    pin_o;

    int n_checks = 0;
    int n_errors = 0;
    int cfg = 0;
    int prev_v [NT];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hrpwm_edge_ext #(.NUM_TIMERS(NT), .CNT_W(CW), .REG_W(RW)) i_hrpwm_edge_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tick      (tick),
        .count_i   (count_i),
        .cmp_i     (cmp_i),
        .pin_o     (pin_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected pin level for fast cycle s of a tick
    function automatic int model(int c, int t, int cnt, int cmp, int s);
        int en, fine, r, pos;
        en = c & 3;
        fine = (c >> 2) & 1;
        if (en == 0) return (cnt < (cmp & 15)) ? 1 : 0;
        if (((en >> t) & 1) == 0) return 0;
        r = fine ? 8 : 4;
        if (cmp < r) return 0;
        pos = cnt * r + (fine ? s : s / 2);
        return (pos < cmp) ? 1 : 0;
    endfunction

    function automatic string tag(int c, int t, int cmp);
        int en;
        en = c & 3;
        if (en == 0) return "R4";
        if (((en >> t) & 1) == 0) return "R3";
        if (cmp < ((((c >> 2) & 1) != 0) ? 8 : 4)) return "R7";
        return (((c >> 2) & 1) != 0) ? "R6" : "R5";
    endfunction

    task automatic write_reg(input int v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v[RW-1:0];
        @(posedge clk);
        #1;
        reg_we = 1'b0;
        cfg = v & 7;
        chk("R1 readback", int'(reg_rdata), v & 7);
    endtask

    task automatic run_period(input int c0, input int m0, input int c1, input int m1,
                              input bit midwr, input int wv);
        int ev [NT][8];
        int cn [NT];
        int cm [NT];
        string lb [NT];
        cn[0] = c0; cn[1] = c1;
        cm[0] = m0; cm[1] = m1;
        for (int t = 0; t < NT; t++) begin
            for (int k = 0; k < 8; k++) ev[t][k] = model(cfg, t, cn[t], cm[t], k);
            lb[t] = midwr ? "R2" : tag(cfg, t, cm[t]);
        end
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            tick = (j == 0);
            if (j == 0) begin
                count_i = {c1[CW-1:0], c0[CW-1:0]};
                cmp_i = {m1[MW-1:0], m0[MW-1:0]};
            end else begin
                count_i = ~count_i;
                cmp_i = cmp_i ^ 14'h2A55;
            end
            reg_we = midwr && (j == 4);
            reg_wdata = wv[RW-1:0];
            @(posedge clk);
            #1;
            for (int t = 0; t < NT; t++) begin
                chk($sformatf("%s R8 pin%0d slot%0d cmp%0d", lb[t], t, j, cm[t]),
                    int'(pin_o[t]), (j == 0) ? prev_v[t] : ev[t][j-1]);
            end
        end
        reg_we = 1'b0;
        for (int t = 0; t < NT; t++) prev_v[t] = ev[t][7];
        if (midwr) cfg = wv & 7;
    endtask

    task automatic sweep(input int c);
        write_reg(c);
        for (int m = 0; m < 128; m++) begin
            for (int n = 0; n < 16; n++) run_period(n, m, n, 127 - m, 1'b0, 0);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        for (int t = 0; t < NT; t++) prev_v[t] = 0;
        repeat (4) @(posedge clk);
        #1;
        chk("R9 pins in reset", int'(pin_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R9 pins after reset", int'(pin_o), 0);
        chk("R1 reset value", int'(reg_rdata), 0);
        write_reg(8'hFF);
        write_reg(8'hF8);
        sweep(3);
        sweep(7);
        sweep(0);
        sweep(1);
        sweep(6);
        // R2: mode rewritten mid-tick, old mode holds until next strobe
        write_reg(3);
        run_period(1, 6, 2, 9, 1'b1, 5);
        run_period(1, 6, 2, 9, 1'b0, 0);
        run_period(0, 13, 0, 40, 1'b1, 2);
        run_period(0, 13, 0, 40, 1'b0, 0);
        run_period(3, 30, 1, 11, 1'b1, 0);
        run_period(3, 30, 1, 11, 1'b0, 0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

endmodule